// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits in front of a NOR flash array that follows the AMD-style command set. Every bus write is a one-cycle strobe that carries a byte address and 16 bits of data. The sequencer decodes these writes into the unlock prefix, command bytes and operand cycles. From them it keeps a command state, an unlock-bypass flag and an erase-suspended flag. Program and erase requests go to a word-organised storage array inside the block. Start, suspend and resume pulses go to a separate erase-timing unit, which reports the end of an erase back on a done input.

Reads are strobed. The data comes back one cycle later from a mux whose source is the current mode. In plain operation the mux returns array words. In autoselect it returns identification words. While an erase runs it returns a status byte. In query mode it returns bytes of a computed capability table. A mode input selects 16-bit bus addressing, where the byte address is shifted right by one before any decode, or 8-bit bus addressing, where the byte address is used as it is.

The block resets into plain read mode with every array word at 0xFFFF.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the block is in read mode with bypass off and no erase suspended. Every array word reads 0xFFFF and no erase-timing pulse is asserted.
- R2: A command needs two prefix writes: data 0xAA at unlock address 0 (default 0x555), then data 0x55 at unlock address 1 (default 0x2AA). The command byte then follows at unlock address 0. A wrong address or wrong data in any of these cycles returns the block to read mode, and the command is then not executed.
- R3: Address decode uses the word-adjusted address. With bus_x16=1 this is the byte address shifted right by one, and with bus_x16=0 it is the byte address itself. Only its low 11 bits take part in the unlock and query-address comparisons.
- R4: The accepted command bytes after the prefix are 0x80 (erase setup), 0x90 (autoselect), 0xA0 (program) and 0x20 (enter bypass). Any other byte returns the block to read mode.
- R5: The write after a program command ANDs its data into the addressed word, so bits can only be cleared. The result is readable on the next read.
- R6: Chip erase is the sequence 0x80, then a second prefix pair, then 0x10 at unlock address 0. It sets every word to 0xFFFF and pulses er_start_o with er_chip_o=1. Writes are ignored until er_done_i is seen, after which the block returns to read mode.
- R7: Sector erase is the sequence 0x80, then a second prefix pair, then 0x30 at any address in a sector (64 words, sector = word index bits 7:6). It sets only that sector to 0xFFFF and pulses er_start_o with er_chip_o=0.
- R8: A read while an erase runs returns a status word with bit 7 = 0 and bit 3 = 1. Bits 6 and 2 invert on every status read: the first status read after reset returns 0x004C and the next returns 0x0008.
- R9: Data 0xF0 returns the block to read mode and clears bypass. It is ignored while an erase runs. When a program command is pending, 0xF0 is taken as program data.
- R10: Data 0x98 at adjusted address 0x55 in read mode enters query mode. There a read at word offset k returns table byte k, for example 0x51, 0x52 and 0x59 at offsets 0x10 to 0x12 and log2 of the byte size at offset 0x27. Offsets at or past 77 return 0. Any other write leaves query mode for read mode.
- R11: In autoselect, word offsets 0 and 1 return ID words 0 and 1, and offset 2 returns 0. Offsets 0x0E and 0x0F return ID words 2 and 3, but an ID word of 0xFFFF falls back to array data. All other offsets return array data.
- R12: The query-entry write issued in autoselect enters a nested query mode. From there 0xF0 returns to autoselect rather than to read mode.
- R13: Command byte 0x20 enters bypass. In bypass, each command is accepted at any address without the prefix, and the block returns to the command cycle after each program. Writing 0x90 and then 0x00 leaves bypass.
- R14: Data 0xB0 during a sector erase pulses er_suspend_o and returns the block to array reads. In that suspended state, 0x30 pulses er_resume_o and brings back status reads. Data 0xB0 in plain read mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_x16 | input | 1 | 1: 16-bit bus addressing (byte address shifted right by one), 0: 8-bit |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 16 | Write data; the command byte is bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 16 | Read result, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after rd_en |
| er_done_i | input | 1 | Erase-timing unit reports the erase finished |
| er_start_o | output | 1 | One-cycle pulse that starts the erase timer |
| er_chip_o | output | 1 | Kind of the running or started erase: 1 chip, 0 sector |
| er_suspend_o | output | 1 | One-cycle pulse that suspends the erase timer |
| er_resume_o | output | 1 | One-cycle pulse that resumes the erase timer |

## Verification
The decoder is driven with complete prefix-and-command sequences and with sequences broken at each stage: a wrong second-cycle address, an unknown command byte, and a command byte at the wrong address. Comparing the array afterwards separates accepted commands from rejected ones. The same program sequence is repeated in 8-bit addressing, with the unused address bit 11 set, to confirm that addresses are adjusted by bus width and compared on 11 bits. The mode transitions are walked through in turn: autoselect into nested query and back, plain query, erase with suspend and resume, chip erase, and bypass entry and exit. The read mux is checked at the ID offsets, including the all-ones fallback, at table offsets below and past the end, and at alternating status reads.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        S_READ, S_UNL1, S_CMD, S_PROG, S_ID,
        S_EU0, S_EU1, S_ECMD, S_BUSY, S_CFI, S_IDCFI
    } seq_state_e;

    typedef enum logic [1:0] {RM_ARRAY, RM_ID, RM_STATUS, RM_CFI} rd_mode_e;

    typedef struct packed {
        logic prog;
        logic erase_all;
        logic erase_sect;
    } arr_req_t;

    localparam logic [7:0]  C_UNL_A  = 8'hAA;
    localparam logic [7:0]  C_UNL_B  = 8'h55;
    localparam logic [7:0]  C_ERASE  = 8'h80;
    localparam logic [7:0]  C_AUTOID = 8'h90;
    localparam logic [7:0]  C_PROG   = 8'hA0;
    localparam logic [7:0]  C_BYPASS = 8'h20;
    localparam logic [7:0]  C_CHIP   = 8'h10;
    localparam logic [7:0]  C_SECT   = 8'h30;
    localparam logic [7:0]  C_SUSP   = 8'hB0;
    localparam logic [7:0]  C_RESET  = 8'hF0;
    localparam logic [7:0]  C_QUERY  = 8'h98;
    localparam logic [7:0]  C_BYPX   = 8'h00;
    localparam logic [10:0] QRY_ADDR = 11'h055;

    function automatic rd_mode_e mode_of(input seq_state_e st);
        case (st)
            S_BUSY:         return RM_STATUS;
            S_ID:           return RM_ID;
            S_CFI, S_IDCFI: return RM_CFI;
            default:        return RM_ARRAY;
        endcase
    endfunction

    // Capability table byte at a word offset; zero past the table length.
    function automatic logic [7:0] cfi_byte(input logic [7:0] off,
                                            input logic [7:0] size_log2,
                                            input logic [7:0] nsect_m1,
                                            input logic [7:0] slen_hi,
                                            input logic [7:0] slen_up,
                                            input int unsigned tbl_len);
        logic [7:0] b;
        case (off)
            8'h10: b = 8'h51;
            8'h11: b = 8'h52;
            8'h12: b = 8'h59;
            8'h13: b = 8'h02;
            8'h15: b = 8'h40;
            8'h1B: b = 8'h27;
            8'h1C: b = 8'h36;
            8'h1F: b = 8'h07;
            8'h21: b = 8'h09;
            8'h22: b = 8'h0C;
            8'h27: b = size_log2;
            8'h28: b = 8'h02;
            8'h2C: b = 8'h01;
            8'h2D: b = nsect_m1;
            8'h2F: b = slen_hi;
            8'h30: b = slen_up;
            8'h40: b = 8'h50;
            8'h41: b = 8'h52;
            8'h42: b = 8'h49;
            8'h43: b = 8'h31;
            8'h44: b = 8'h30;
            8'h46: b = 8'h02;
            default: b = 8'h00;
        endcase
        if (32'(off) >= tbl_len) b = 8'h00;
        return b;
    endfunction

endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter logic [10:0] UNLOCK0 = 11'h555,
    parameter logic [10:0] UNLOCK1 = 11'h2AA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [10:0] wr_adj,
    input  logic [7:0] wr_cmd,
    input  logic       er_done_i,
    output seq_state_e state_o,
    output arr_req_t   req_o,
    output logic       er_start_o,
    output logic       er_chip_o,
    output logic       er_suspend_o,
    output logic       er_resume_o
);
    seq_state_e state, nxt_state;
    logic byp, nxt_byp, susp, nxt_susp, chip, nxt_chip;
    logic start_n, susp_n, res_n;
    logic hit0, hit1;

    assign hit0 = (wr_adj == UNLOCK0);
    assign hit1 = (wr_adj == UNLOCK1);

    always_comb begin
        nxt_state = state;
        nxt_byp   = byp;
        nxt_susp  = susp;
        nxt_chip  = chip;
        req_o     = '0;
        start_n   = 1'b0;
        susp_n    = 1'b0;
        res_n     = 1'b0;
        if (wr_en) begin
            if (wr_cmd == C_RESET && state != S_PROG && state != S_BUSY) begin
                if (state == S_IDCFI) nxt_state = S_ID;
                else begin
                    nxt_state = S_READ;
                    nxt_byp   = 1'b0;
                end
            end else begin
                case (state)
                    S_READ: begin
                        if (wr_adj == QRY_ADDR && wr_cmd == C_QUERY) nxt_state = S_CFI;
                        else if (wr_cmd == C_SECT) begin
                            if (susp) begin
                                res_n     = 1'b1;
                                nxt_susp  = 1'b0;
                                nxt_state = S_BUSY;
                            end else nxt_byp = 1'b0;
                        end else if (wr_cmd == C_SUSP) begin
                        end else if (hit0 && wr_cmd == C_UNL_A) nxt_state = S_UNL1;
                        else nxt_byp = 1'b0;
                    end
                    S_UNL1: begin
                        if (hit1 && wr_cmd == C_UNL_B) nxt_state = S_CMD;
                        else begin nxt_state = S_READ; nxt_byp = 1'b0; end
                    end
                    S_CMD: begin
                        if (!byp && !hit0) begin
                            nxt_state = S_READ; nxt_byp = 1'b0;
                        end else begin
                            case (wr_cmd)
                                C_BYPASS: nxt_byp   = 1'b1;
                                C_ERASE:  nxt_state = S_EU0;
                                C_AUTOID: nxt_state = S_ID;
                                C_PROG:   nxt_state = S_PROG;
                                default: begin nxt_state = S_READ; nxt_byp = 1'b0; end
                            endcase
                        end
                    end
                    S_PROG: begin
                        req_o.prog = 1'b1;
                        nxt_state  = byp ? S_CMD : S_READ;
                    end
                    S_ID: begin
                        if (!(byp && wr_cmd == C_BYPX) && wr_adj == QRY_ADDR && wr_cmd == C_QUERY)
                            nxt_state = S_IDCFI;
                        else begin nxt_state = S_READ; nxt_byp = 1'b0; end
                    end
                    S_EU0: begin
                        if (hit0 && wr_cmd == C_UNL_A) nxt_state = S_EU1;
                        else begin nxt_state = S_READ; nxt_byp = 1'b0; end
                    end
                    S_EU1: begin
                        if (hit1 && wr_cmd == C_UNL_B) nxt_state = S_ECMD;
                        else begin nxt_state = S_READ; nxt_byp = 1'b0; end
                    end
                    S_ECMD: begin
                        if (!susp && wr_cmd == C_CHIP && hit0) begin
                            req_o.erase_all = 1'b1;
                            start_n   = 1'b1;
                            nxt_chip  = 1'b1;
                            nxt_state = S_BUSY;
                        end else if (!susp && wr_cmd == C_SECT) begin
                            req_o.erase_sect = 1'b1;
                            start_n   = 1'b1;
                            nxt_chip  = 1'b0;
                            nxt_state = S_BUSY;
                        end else begin nxt_state = S_READ; nxt_byp = 1'b0; end
                    end
                    S_BUSY: begin
                        if (!chip && wr_cmd == C_SUSP) begin
                            susp_n    = 1'b1;
                            nxt_susp  = 1'b1;
                            nxt_state = S_READ;
                        end
                    end
                    default: begin nxt_state = S_READ; nxt_byp = 1'b0; end
                endcase
            end
        end
        if (state == S_BUSY && er_done_i && !susp_n) nxt_state = byp ? S_CMD : S_READ;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= S_READ;
            byp          <= 1'b0;
            susp         <= 1'b0;
            chip         <= 1'b0;
            er_start_o   <= 1'b0;
            er_suspend_o <= 1'b0;
            er_resume_o  <= 1'b0;
        end else begin
            state        <= nxt_state;
            byp          <= nxt_byp;
            susp         <= nxt_susp;
            chip         <= nxt_chip;
            er_start_o   <= start_n;
            er_suspend_o <= susp_n;
            er_resume_o  <= res_n;
        end
    end

    assign state_o   = state;
    assign er_chip_o = chip;

    AST_START_ENTERS_BUSY: assert property (@(posedge clk) disable iff (rst)
        er_start_o |-> state == S_BUSY); // R6
    AST_RESET_IGNORED_IN_ERASE: assert property (@(posedge clk) disable iff (rst)
        (state == S_BUSY && wr_en && wr_cmd == C_RESET && !er_done_i) |=> state == S_BUSY); // R9
    AST_RESUME_AFTER_SUSPEND: assert property (@(posedge clk) disable iff (rst)
        er_resume_o |-> (state == S_BUSY && !susp)); // R14
endmodule

// File: rtl/flash_store.sv
module flash_store
    import flash_seq_pkg::*;
#(
    parameter int WORDS     = 256,
    parameter int SEC_WORDS = 64,
    localparam int AW = $clog2(WORDS),
    localparam int SW = $clog2(SEC_WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  arr_req_t      req,
    input  logic [AW-1:0] prog_idx,
    input  logic [15:0]   prog_data,
    input  logic [AW-1:0] rd_idx,
    output logic [15:0]   rd_word
);
    logic [15:0] mem [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [AW-1:0] WI = AW'(w);
        logic sect_hit;
        assign sect_hit = (prog_idx[AW-1:SW] == WI[AW-1:SW]);
        always_ff @(posedge clk) begin
            if (rst) mem[w] <= 16'hFFFF;
            else if (req.erase_all || (req.erase_sect && sect_hit)) mem[w] <= 16'hFFFF;
            else if (req.prog && prog_idx == WI) mem[w] <= mem[w] & prog_data;
        end
    end

    assign rd_word = mem[rd_idx];

    AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        req.prog |=> ((mem[$past(prog_idx)] & ~$past(mem[prog_idx])) == 16'h0000)); // R5
endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_seq_pkg::*;
#(
    parameter logic [15:0] ID0 = 16'h0001,
    parameter logic [15:0] ID1 = 16'h227E,
    parameter logic [15:0] ID2 = 16'h2221,
    parameter logic [15:0] ID3 = 16'hFFFF,
    parameter int WORDS     = 256,
    parameter int SEC_WORDS = 64,
    parameter int CFI_LEN   = 77
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  logic [7:0]  rd_off,
    input  seq_state_e  state,
    input  logic [15:0] arr_word,
    output logic [15:0] rd_data,
    output logic        rd_valid
);
    localparam logic [7:0] P_SIZE = 8'($clog2(WORDS * 2));
    localparam logic [7:0] P_NSM1 = 8'(WORDS / SEC_WORDS - 1);
    localparam logic [7:0] P_SLH  = 8'((SEC_WORDS * 2) >> 8);
    localparam logic [7:0] P_SLU  = 8'((SEC_WORDS * 2) >> 16);

    rd_mode_e    mode;
    logic        tog;
    logic [15:0] nxt;

    assign mode = mode_of(state);

    always_comb begin
        case (mode)
            RM_STATUS: nxt = {8'h00, 1'b0, ~tog, 3'b001, ~tog, 2'b00};
            RM_CFI:    nxt = {8'h00, cfi_byte(rd_off, P_SIZE, P_NSM1, P_SLH, P_SLU, CFI_LEN)};
            RM_ID: begin
                case (rd_off)
                    8'h00:   nxt = ID0;
                    8'h01:   nxt = ID1;
                    8'h02:   nxt = 16'h0000;
                    8'h0E:   nxt = (ID2 == 16'hFFFF) ? arr_word : ID2;
                    8'h0F:   nxt = (ID3 == 16'hFFFF) ? arr_word : ID3;
                    default: nxt = arr_word;
                endcase
            end
            default:   nxt = arr_word;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= 16'h0000;
            tog      <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= nxt;
                if (mode == RM_STATUS) tog <= ~tog;
            end
        end
    end

    AST_STATUS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && mode == RM_STATUS) |=> (rd_data[7] == 1'b0 && rd_data[3] == 1'b1)); // R8
    AST_CFI_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && mode == RM_CFI && 32'(rd_off) >= CFI_LEN) |=> rd_data == 16'h0000); // R10
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          WORDS     = 256,
    parameter int          SEC_WORDS = 64,
    parameter int          CFI_LEN   = 77,
    parameter logic [10:0] UNLOCK0   = 11'h555,
    parameter logic [10:0] UNLOCK1   = 11'h2AA,
    parameter logic [15:0] ID0       = 16'h0001,
    parameter logic [15:0] ID1       = 16'h227E,
    parameter logic [15:0] ID2       = 16'h2221,
    parameter logic [15:0] ID3       = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_x16,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    input  logic              er_done_i,
    output logic              er_start_o,
    output logic              er_chip_o,
    output logic              er_suspend_o,
    output logic              er_resume_o
);
    localparam int AW = $clog2(WORDS);

    logic [ADDR_W-1:0] wr_adj, rd_adj;
    seq_state_e        state;
    arr_req_t          req;
    logic [15:0]       arr_word;

    assign wr_adj = bus_x16 ? {1'b0, wr_addr[ADDR_W-1:1]} : wr_addr;
    assign rd_adj = bus_x16 ? {1'b0, rd_addr[ADDR_W-1:1]} : rd_addr;

    flash_cmd_fsm #(.UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)) u_fsm (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_adj(wr_adj[10:0]),
        .wr_cmd(wr_data[7:0]), .er_done_i(er_done_i), .state_o(state),
        .req_o(req), .er_start_o(er_start_o), .er_chip_o(er_chip_o),
        .er_suspend_o(er_suspend_o), .er_resume_o(er_resume_o)
    );

    flash_store #(.WORDS(WORDS), .SEC_WORDS(SEC_WORDS)) u_store (
        .clk(clk), .rst(rst), .req(req), .prog_idx(wr_adj[AW-1:0]),
        .prog_data(wr_data), .rd_idx(rd_adj[AW-1:0]), .rd_word(arr_word)
    );

    flash_read_mux #(.ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3),
                     .WORDS(WORDS), .SEC_WORDS(SEC_WORDS), .CFI_LEN(CFI_LEN)) u_rmux (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_off(rd_adj[7:0]),
        .state(state), .arr_word(arr_word), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_x16 = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        er_done_i = 1'b0;
    logic        er_start_o, er_chip_o, er_suspend_o, er_resume_o;

    int total = 0;
    int bad = 0;
    bit stog = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    localparam logic [11:0] U0B = 12'hAAA;
    localparam logic [11:0] U1B = 12'h554;
    localparam logic [11:0] QB  = 12'h0AA;

    always #4 clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst(rst), .bus_x16(bus_x16), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .er_done_i(er_done_i), .er_start_o(er_start_o),
        .er_chip_o(er_chip_o), .er_suspend_o(er_suspend_o), .er_resume_o(er_resume_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // word-addressed helper for 16-bit mode
    task automatic wrw(input logic [10:0] w, input logic [15:0] d);
        wr({w, 1'b0}, d);
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rdw(input logic [10:0] w, input logic [15:0] exp, input string tag);
        rd({w, 1'b0}, exp, tag);
    endtask

    task automatic rd_status(input string tag);
        rd(12'h000, stog ? 16'h0008 : 16'h004C, tag);
        stog = ~stog;
    endtask

    task automatic prefix();
        wr(U0B, 16'h00AA);
        wr(U1B, 16'h0055);
    endtask

    task automatic program_word(input logic [10:0] w, input logic [15:0] d);
        prefix();
        wr(U0B, 16'h00A0);
        wrw(w, d);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        er_done_i = 1'b1;
        @(negedge clk);
        er_done_i = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL unexpected read: actual=%h expected=none", rd_data);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 start pulse", {15'h0, er_start_o}, 16'h0);
        check("R1 suspend/resume", {14'h0, er_suspend_o, er_resume_o}, 16'h0);
        rdw(11'h010, 16'hFFFF, "R1 erased word");

        // R5 program ANDs data
        program_word(11'h010, 16'h1234);
        rdw(11'h010, 16'h1234, "R5 first program");
        program_word(11'h010, 16'h0F0F);
        rdw(11'h010, 16'h0204, "R5 AND program");
        // R9 pending program takes F0 as data
        program_word(11'h011, 16'h00F0);
        rdw(11'h011, 16'h00F0, "R9 F0 as program data");
        program_word(11'h00F, 16'hABCD);
        program_word(11'h045, 16'h1111);

        // R2 wrong second-cycle address
        wr(U0B, 16'h00AA); wr(12'h556, 16'h0055); wr(U0B, 16'h00A0); wrw(11'h012, 16'h0000);
        rdw(11'h012, 16'hFFFF, "R2 broken prefix");
        // R4 unknown command byte, then command at wrong address
        prefix(); wr(U0B, 16'h0077); wrw(11'h012, 16'h0000);
        rdw(11'h012, 16'hFFFF, "R4 unknown command");
        prefix(); wr(12'h556, 16'h00A0); wrw(11'h013, 16'h0000);
        rdw(11'h013, 16'hFFFF, "R2 command at wrong address");

        // R3 8-bit addressing, bit 11 ignored in compare
        bus_x16 = 1'b0;
        wr(12'hD55, 16'h00AA); wr(12'hAAA, 16'h0055); wr(12'hD55, 16'h00A0); wr(12'h020, 16'h00FF);
        rd(12'h020, 16'h00FF, "R3 x8 program with bit 11 set");
        bus_x16 = 1'b1;

        // R11 autoselect
        prefix(); wr(U0B, 16'h0090);
        rdw(11'h000, 16'h0001, "R11 id0");
        rdw(11'h001, 16'h227E, "R11 id1");
        rdw(11'h002, 16'h0000, "R11 protect word");
        rdw(11'h00E, 16'h2221, "R11 id2");
        rdw(11'h00F, 16'hABCD, "R11 id3 fallback");
        rdw(11'h010, 16'h0204, "R11 other offset");
        // R12 nested query and back
        wr(QB, 16'h0098);
        rdw(11'h010, 16'h0051, "R12 nested query");
        wr(12'h000, 16'h00F0);
        rdw(11'h000, 16'h0001, "R12 back to autoselect");
        wr(12'h000, 16'h00F0);
        rdw(11'h00F, 16'hABCD, "R9 reset to read");

        // R10 query mode
        wr(QB, 16'h0098);
        rdw(11'h010, 16'h0051, "R10 Q");
        rdw(11'h011, 16'h0052, "R10 R");
        rdw(11'h012, 16'h0059, "R10 Y");
        rdw(11'h027, 16'h0009, "R10 size");
        rdw(11'h04D, 16'h0000, "R10 past end");
        wr(12'h000, 16'h0000);
        rdw(11'h010, 16'h0204, "R10 exit to read");

        // R7 sector erase via address inside sector 0
        prefix(); wr(U0B, 16'h0080); prefix(); wrw(11'h020, 16'h0030);
        check("R7 start pulse", {15'h0, er_start_o}, 16'h1);
        check("R7 kind sector", {15'h0, er_chip_o}, 16'h0);
        rd_status("R8 status first");
        rd_status("R8 status second");
        wr(12'h000, 16'h00F0);
        rd_status("R9 reset ignored in erase");
        // R14 suspend
        wr(12'h000, 16'h00B0);
        check("R14 suspend pulse", {15'h0, er_suspend_o}, 16'h1);
        rdw(11'h010, 16'hFFFF, "R7 sector erased");
        rdw(11'h045, 16'h1111, "R7 other sector kept");
        wr(12'h000, 16'h00B0);
        rdw(11'h00F, 16'hFFFF, "R14 B0 ignored in read");
        wr(12'h010, 16'h0030);
        check("R14 resume pulse", {15'h0, er_resume_o}, 16'h1);
        rd_status("R14 status after resume");
        done_pulse();
        rdw(11'h045, 16'h1111, "R7 back to read");

        // R6 chip erase
        prefix(); wr(U0B, 16'h0080); prefix(); wr(U0B, 16'h0010);
        check("R6 start pulse", {15'h0, er_start_o}, 16'h1);
        check("R6 kind chip", {15'h0, er_chip_o}, 16'h1);
        wr(U0B, 16'h00AA);
        rd_status("R6 write ignored while busy");
        done_pulse();
        rdw(11'h045, 16'hFFFF, "R6 all erased");
        rdw(11'h011, 16'hFFFF, "R6 all erased 2");

        // R13 bypass
        prefix(); wr(U0B, 16'h0020);
        wr(12'h002, 16'h00A0); wrw(11'h030, 16'h5A5A);
        rdw(11'h030, 16'h5A5A, "R13 bypass program 1");
        wr(12'h004, 16'h00A0); wrw(11'h031, 16'h0F0F);
        rdw(11'h031, 16'h0F0F, "R13 bypass program 2");
        wr(12'h006, 16'h0090); wr(12'h006, 16'h0000);
        wr(U0B, 16'h00A0); wrw(11'h032, 16'h0000);
        rdw(11'h032, 16'hFFFF, "R13 bypass left");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule